// File: doc/BRIEF.md
# Windowed Outbound Address Decoder

This block decides whether a processor-side memory address in the upper 256 MiB region goes out to the PCI bus. That region starts at 0xF0000000 and is cut into 32 windows of 8 MiB each. Each window has its own enable bit in a 32-bit enable word. The first window is reserved for firmware and the last belongs to the bridge itself, so neither of them ever forwards. A two-bit gate field in a control word switches all forwarding on or off at once. Both words are written and read through a small register port. A forwarded address goes to PCI memory unchanged.

A second, independent path classifies addresses issued by PCI bus masters. The target is one of: system memory, PCI memory, processor space, or nothing. The address itself passes through unchanged. Both decode paths are purely combinational from the current address and the registered state.

The gate is kept by a two-state machine. GATE_CLOSED is the reset state. A control-word write whose gate field is 2'b01 moves it to GATE_OPEN (the open transition). In GATE_OPEN, a control-word write with any other gate value returns it to GATE_CLOSED (the close transition). All other cycles hold the state. In GATE_CLOSED the effective window mask is zero. In GATE_OPEN it is the enable word with the two edge windows removed.

Top module: `outbound_window_decoder`

## Requirements
- R1: After a synchronous active-low reset, both register words read as zero, the gate is closed, and no address produces a hit.
- R2: Register address 0 holds the 32-bit enable word and address 1 holds the 32-bit control word. Both read back exactly as written. Addresses 2 and 3 read as zero, and writes to them change nothing.
- R3: Window i covers 0xF0000000 + i*0x800000 through the next 8 MiB. For i from 1 to 30, an address in window i hits when enable bit i is set and the gate is open.
- R4: Windows 0 and 31 never hit, whatever is stored in enable bits 0 and 31.
- R5: The gate is open only when control bits [8:7] equal 2'b01. The values 2'b00, 2'b10 and 2'b11 suppress every hit.
- R6: A register write is sampled on a rising clock edge, and the hit output reflects it from that edge onward. Before that edge, the old state still applies.
- R7: An outbound address below 0xF0000000 never hits.
- R8: The forward address output equals the processor address while the hit output is high, and is zero otherwise.
- R9: An inbound address below 0xF0800000 gets target code 2'b00 (system memory).
- R10: An inbound address from 0xF0800000 through 0xFF7FFFFF gets target code 2'b01 (PCI memory).
- R11: An inbound address from 0xFFF00000 upward gets target code 2'b10 (processor space).
- R12: An inbound address from 0xFF800000 through 0xFFEFFFFF gets target code 2'b11 (unmapped).
- R13: The inbound address output always equals the inbound address input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| cpu_addr | input | 32 | Outbound processor address |
| fwd_hit | output | 1 | Outbound address is forwarded |
| fwd_addr | output | 32 | Forwarded PCI memory address |
| bm_addr | input | 32 | Inbound bus-master address |
| bm_target | output | 2 | Inbound target code |
| bm_addr_out | output | 32 | Inbound address passed through |

## Verification
The bench builds the block with its default parameters: 32 windows of 8 MiB based at 0xF0000000, and processor space at 0xFFF00000. With these values every window can be reached, including both excluded edge windows. Every inbound range boundary is also reachable, at its first and last byte. The probes sweep each window at its first, middle and last byte under all four gate values and several enable patterns. A behavioural model in the bench is compared against all outputs on every clock.

// File: rtl/owd_pkg.sv
package owd_pkg;

    // Position and open value of the forwarding gate field in the control word
    localparam int          GATE_LSB = 7;
    localparam int          GATE_W   = 2;
    localparam logic [1:0]  GATE_ON  = 2'b01;

    typedef enum logic [0:0] {
        GATE_CLOSED = 1'b0,
        GATE_OPEN   = 1'b1
    } gate_state_t;

    typedef enum logic [1:0] {
        TGT_SYS  = 2'b00,
        TGT_PCI  = 2'b01,
        TGT_CPU  = 2'b10,
        TGT_NONE = 2'b11
    } bm_tgt_t;

endpackage

// File: rtl/owd_regs.sv
module owd_regs
    import owd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_WIN = 32,
    parameter int REG_AW  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [DATA_W-1:0]   en_word,
    output logic [DATA_W-1:0]   ctrl_word,
    output logic [NUM_WIN-1:0]  eff_mask
);

    localparam logic [REG_AW-1:0] ADR_EN   = REG_AW'(0);
    localparam logic [REG_AW-1:0] ADR_CTRL = REG_AW'(1);

    gate_state_t        state_q;
    gate_state_t        state_nx;
    logic               wr_en_word;
    logic               wr_ctrl_word;
    logic [GATE_W-1:0]  new_gate;
    logic [NUM_WIN-1:0] interior;

    assign wr_en_word   = reg_wr && (reg_addr == ADR_EN);
    assign wr_ctrl_word = reg_wr && (reg_addr == ADR_CTRL);
    assign new_gate     = reg_wdata[GATE_LSB +: GATE_W];

    // Edge windows (firmware area and the bridge's own area) never forward
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_interior
        if (i == 0 || i == NUM_WIN - 1) begin : g_edge
            assign interior[i] = 1'b0;
        end else begin : g_mid
            assign interior[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_word   <= '0;
            ctrl_word <= '0;
        end else begin
            if (wr_en_word) begin
                en_word <= reg_wdata;
            end
            if (wr_ctrl_word) begin
                ctrl_word <= reg_wdata;
            end
        end
    end

    // Gate state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_CLOSED;
        end else begin
            state_q <= state_nx;
        end
    end

    // Gate transitions: re-evaluated on every control word write
    always_comb begin
        state_nx = state_q;
        if (wr_ctrl_word) begin
            unique case (state_q)
                GATE_CLOSED: if (new_gate == GATE_ON) state_nx = GATE_OPEN;
                GATE_OPEN:   if (new_gate != GATE_ON) state_nx = GATE_CLOSED;
                default:     state_nx = GATE_CLOSED;
            endcase
        end
    end

    // State outputs: effective window mask
    always_comb begin
        unique case (state_q)
            GATE_OPEN: eff_mask = en_word[NUM_WIN-1:0] & interior;
            default:   eff_mask = '0;
        endcase
    end

    always_comb begin
        unique case (reg_addr)
            ADR_EN:   reg_rdata = en_word;
            ADR_CTRL: reg_rdata = ctrl_word;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/owd_outbound.sv
module owd_outbound #(
    parameter int              ADDR_W      = 32,
    parameter int              NUM_WIN     = 32,
    parameter int              WIN_SHIFT   = 23,
    parameter logic [31:0]     REGION_BASE = 32'hF000_0000
) (
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [NUM_WIN-1:0] eff_mask,
    output logic               fwd_hit,
    output logic [ADDR_W-1:0]  fwd_addr
);

    localparam int IDX_W       = $clog2(NUM_WIN);
    localparam int REGION_BITS = IDX_W + WIN_SHIFT;
    localparam int TAG_W       = ADDR_W - REGION_BITS;
    localparam logic [TAG_W-1:0] REGION_TAG = REGION_BASE[ADDR_W-1:REGION_BITS];

    logic               in_region;
    logic [IDX_W-1:0]   win_idx;
    logic [NUM_WIN-1:0] win_sel;

    assign in_region = (cpu_addr[ADDR_W-1:REGION_BITS] == REGION_TAG);
    assign win_idx   = cpu_addr[REGION_BITS-1:WIN_SHIFT];

    // One-hot window match, one comparator per window
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        assign win_sel[i] = in_region && (win_idx == IDX_W'(i));
    end

    assign fwd_hit  = |(win_sel & eff_mask);
    assign fwd_addr = fwd_hit ? cpu_addr : '0;

endmodule

// File: rtl/owd_inbound.sv
module owd_inbound
    import owd_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          NUM_WIN     = 32,
    parameter int          WIN_SHIFT   = 23,
    parameter logic [31:0] REGION_BASE = 32'hF000_0000,
    parameter logic [31:0] CPU_BASE    = 32'hFFF0_0000
) (
    input  logic [ADDR_W-1:0] bm_addr,
    output bm_tgt_t           bm_tgt,
    output logic [ADDR_W-1:0] bm_addr_out
);

    localparam logic [ADDR_W-1:0] WIN_SIZE  = ADDR_W'(1) << WIN_SHIFT;
    localparam logic [ADDR_W-1:0] SYS_LIMIT = REGION_BASE + WIN_SIZE;
    localparam logic [ADDR_W-1:0] PCI_LIMIT = REGION_BASE + WIN_SIZE * ADDR_W'(NUM_WIN - 1);

    always_comb begin
        if (bm_addr < SYS_LIMIT) begin
            bm_tgt = TGT_SYS;
        end else if (bm_addr < PCI_LIMIT) begin
            bm_tgt = TGT_PCI;
        end else if (bm_addr >= CPU_BASE) begin
            bm_tgt = TGT_CPU;
        end else begin
            bm_tgt = TGT_NONE;
        end
    end

    assign bm_addr_out = bm_addr;

endmodule

// File: rtl/outbound_window_decoder.sv
module outbound_window_decoder
    import owd_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          NUM_WIN     = 32,
    parameter int          WIN_SHIFT   = 23,
    parameter int          REG_AW      = 2,
    parameter logic [31:0] REGION_BASE = 32'hF000_0000,
    parameter logic [31:0] CPU_BASE    = 32'hFFF0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              fwd_hit,
    output logic [ADDR_W-1:0] fwd_addr,
    input  logic [ADDR_W-1:0] bm_addr,
    output logic [1:0]        bm_target,
    output logic [ADDR_W-1:0] bm_addr_out
);

    logic [ADDR_W-1:0]  en_word;
    logic [ADDR_W-1:0]  ctrl_word;
    logic [NUM_WIN-1:0] eff_mask;
    bm_tgt_t            tgt;

    owd_regs #(
        .DATA_W  (ADDR_W),
        .NUM_WIN (NUM_WIN),
        .REG_AW  (REG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .en_word   (en_word),
        .ctrl_word (ctrl_word),
        .eff_mask  (eff_mask)
    );

    owd_outbound #(
        .ADDR_W      (ADDR_W),
        .NUM_WIN     (NUM_WIN),
        .WIN_SHIFT   (WIN_SHIFT),
        .REGION_BASE (REGION_BASE)
    ) u_out (
        .cpu_addr (cpu_addr),
        .eff_mask (eff_mask),
        .fwd_hit  (fwd_hit),
        .fwd_addr (fwd_addr)
    );

    owd_inbound #(
        .ADDR_W      (ADDR_W),
        .NUM_WIN     (NUM_WIN),
        .WIN_SHIFT   (WIN_SHIFT),
        .REGION_BASE (REGION_BASE),
        .CPU_BASE    (CPU_BASE)
    ) u_in (
        .bm_addr     (bm_addr),
        .bm_tgt      (tgt),
        .bm_addr_out (bm_addr_out)
    );

    assign bm_target = tgt;

endmodule

// File: rtl/owd_checker.sv
module owd_checker #(
    parameter int          ADDR_W      = 32,
    parameter int          WIN_SHIFT   = 23,
    parameter int          NUM_WIN     = 32,
    parameter int          REG_AW      = 2,
    parameter logic [31:0] REGION_BASE = 32'hF000_0000,
    parameter logic [31:0] CPU_BASE    = 32'hFFF0_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [ADDR_W-1:0] reg_wdata,
    input logic [ADDR_W-1:0] en_word,
    input logic [ADDR_W-1:0] ctrl_word,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              fwd_hit,
    input logic [ADDR_W-1:0] fwd_addr,
    input logic [ADDR_W-1:0] bm_addr,
    input logic [1:0]        bm_target,
    input logic [ADDR_W-1:0] bm_addr_out
);

    localparam logic [ADDR_W-1:0] WIN_SIZE   = ADDR_W'(1) << WIN_SHIFT;
    localparam logic [ADDR_W-1:0] FIRST_END  = REGION_BASE + WIN_SIZE;
    localparam logic [ADDR_W-1:0] LAST_START = REGION_BASE + WIN_SIZE * ADDR_W'(NUM_WIN - 1);

    a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_AW'(0)) |=> (en_word == $past(reg_wdata)));

    a_r6_control_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_AW'(1)) |=> (ctrl_word == $past(reg_wdata)));

    a_r4_edge_windows_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_addr >= REGION_BASE && cpu_addr < FIRST_END) || cpu_addr >= LAST_START) |-> !fwd_hit);

    a_r5_gate_closed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[8:7] != 2'b01) |-> !fwd_hit);

    a_r3_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit |-> en_word[cpu_addr[WIN_SHIFT +: 5]]);

    a_r7_low_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < REGION_BASE) |-> !fwd_hit);

    a_r8_forward_address: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_addr == (fwd_hit ? cpu_addr : '0));

    a_r11_cpu_space: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_addr >= CPU_BASE) |-> (bm_target == 2'b10));

    a_r12_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_addr >= LAST_START && bm_addr < CPU_BASE) |-> (bm_target == 2'b11));

    a_r13_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        bm_addr_out == bm_addr);

endmodule

bind outbound_window_decoder owd_checker #(
    .ADDR_W      (ADDR_W),
    .WIN_SHIFT   (WIN_SHIFT),
    .NUM_WIN     (NUM_WIN),
    .REG_AW      (REG_AW),
    .REGION_BASE (REGION_BASE),
    .CPU_BASE    (CPU_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .en_word     (en_word),
    .ctrl_word   (ctrl_word),
    .cpu_addr    (cpu_addr),
    .fwd_hit     (fwd_hit),
    .fwd_addr    (fwd_addr),
    .bm_addr     (bm_addr),
    .bm_target   (bm_target),
    .bm_addr_out (bm_addr_out)
);

// File: tb/outbound_window_decoder_test.sv
module outbound_window_decoder_test;

    localparam int PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] cpu_addr = '0;
    logic        fwd_hit;
    logic [31:0] fwd_addr;
    logic [31:0] bm_addr = '0;
    logic [1:0]  bm_target;
    logic [31:0] bm_addr_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] m_en;
    logic [31:0] m_ctrl;

    always #(PERIOD/2) clk = ~clk;

    outbound_window_decoder uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
        .fwd_hit(fwd_hit), .fwd_addr(fwd_addr), .bm_addr(bm_addr),
        .bm_target(bm_target), .bm_addr_out(bm_addr_out)
    );

    // Behavioural reference state
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en   <= 32'h0;
            m_ctrl <= 32'h0;
        end else if (reg_wr) begin
            if (reg_addr == 2'd0) m_en <= reg_wdata;
            else if (reg_addr == 2'd1) m_ctrl <= reg_wdata;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_hit(input logic [31:0] a);
        longint idx;
        if (a < 32'hF000_0000) return 1'b0;
        idx = (longint'(a) - 64'hF000_0000) / 64'h80_0000;
        if (((m_ctrl >> 7) & 32'h3) != 32'h1) return 1'b0;
        if (idx == 0 || idx == 31) return 1'b0;
        return m_en[idx];
    endfunction

    function automatic string hit_tag(input logic [31:0] a);
        longint idx;
        if (a < 32'hF000_0000) return "R7 hit";
        idx = (longint'(a) - 64'hF000_0000) / 64'h80_0000;
        if (idx == 0 || idx == 31) return "R4 hit";
        if (((m_ctrl >> 7) & 32'h3) != 32'h1) return "R5 hit";
        return "R3 hit";
    endfunction

    function automatic logic [1:0] exp_tgt(input logic [31:0] a);
        if (a < 32'hF080_0000) return 2'd0;
        if (a <= 32'hFF7F_FFFF) return 2'd1;
        if (a >= 32'hFFF0_0000) return 2'd2;
        return 2'd3;
    endfunction

    function automatic string tgt_tag(input logic [31:0] a);
        case (exp_tgt(a))
            2'd0:    return "R9 target";
            2'd1:    return "R10 target";
            2'd2:    return "R11 target";
            default: return "R12 target";
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input logic [1:0] ra);
        if (ra == 2'd0) return m_en;
        if (ra == 2'd1) return m_ctrl;
        return 32'h0;
    endfunction

    // Per-clock comparison, a quarter period after the falling edge
    always @(negedge clk) begin
        #(PERIOD/4);
        if (rst_n && !done) begin
            check("R2 rdata", reg_rdata, exp_rd(reg_addr));
            check(hit_tag(cpu_addr), {31'h0, fwd_hit}, {31'h0, exp_hit(cpu_addr)});
            check("R8 fwd_addr", fwd_addr, exp_hit(cpu_addr) ? cpu_addr : 32'h0);
            check(tgt_tag(bm_addr), {30'h0, bm_target}, {30'h0, exp_tgt(bm_addr)});
            check("R13 passthrough", bm_addr_out, bm_addr);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic probe(input logic [31:0] c, input logic [31:0] b);
        @(negedge clk);
        cpu_addr = c; bm_addr = b;
    endtask

    task automatic sweep();
        for (int w = 0; w < 32; w++) begin
            probe(32'hF000_0000 + w * 32'h80_0000, 32'hF000_0000 + w * 32'h80_0000);
            probe(32'hF040_0000 + w * 32'h80_0000, 32'h0100_0000 * w);
            probe(32'hF07F_FFFF + w * 32'h80_0000, 32'hFF80_0000 + w * 32'h4_0000);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cpu_addr = 32'hF280_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(PERIOD/4);
        // R1: reset state
        reg_addr = 2'd0; #1;
        check("R1 enable reset", reg_rdata, 32'h0);
        reg_addr = 2'd1; #1;
        check("R1 control reset", reg_rdata, 32'h0);
        check("R1 no hit", {31'h0, fwd_hit}, 32'h0);

        // R5: all enabled but gate closed
        wr(2'd0, 32'hFFFF_FFFF);
        sweep();
        // R2: unused addresses
        wr(2'd2, 32'h1234_5678);
        wr(2'd3, 32'hFFFF_FFFF);
        @(negedge clk); reg_addr = 2'd2; #(PERIOD/4 + 1);
        check("R2 unused read", reg_rdata, 32'h0);
        reg_addr = 2'd0; #1;
        check("R2 enable kept", reg_rdata, 32'hFFFF_FFFF);

        wr(2'd1, 32'h0000_0080);   // gate 01
        sweep();
        wr(2'd0, 32'hAAAA_AAAA);
        sweep();
        wr(2'd0, 32'h5555_5555);
        sweep();
        wr(2'd1, 32'h0000_0100);   // gate 10
        sweep();
        wr(2'd1, 32'hFFFF_FFFF);   // gate 11
        sweep();

        // R6: write takes effect at the sampling edge
        wr(2'd1, 32'h0000_0080);
        wr(2'd0, 32'h0000_0000);
        @(negedge clk);
        cpu_addr = 32'hF280_0010;
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0000_0020;
        #(PERIOD/4 + 1);
        check("R6 before edge", {31'h0, fwd_hit}, 32'h0);
        @(negedge clk);
        reg_wr = 1'b0;
        #(PERIOD/4 + 1);
        check("R6 after edge", {31'h0, fwd_hit}, 32'h1);
        check("R8 forwarded", fwd_addr, 32'hF280_0010);

        // R4: edge enable bits stored but ignored
        wr(2'd0, 32'h8000_0001);
        probe(32'hF000_0000, 32'hF07F_FFFF);
        #(PERIOD/4 + 1);
        check("R4 window 0", {31'h0, fwd_hit}, 32'h0);
        probe(32'hFFFF_FFFF, 32'hFFEF_FFFF);
        #(PERIOD/4 + 1);
        check("R4 window 31", {31'h0, fwd_hit}, 32'h0);
        check("R12 top unmapped", {30'h0, bm_target}, 32'h3);
        probe(32'hEFFF_FFFF, 32'hFFF0_0000);
        #(PERIOD/4 + 1);
        check("R7 below region", {31'h0, fwd_hit}, 32'h0);
        check("R11 cpu base", {30'h0, bm_target}, 32'h2);
        probe(32'h0, 32'hF080_0000);
        #(PERIOD/4 + 1);
        check("R10 pci base", {30'h0, bm_target}, 32'h1);
        probe(32'h0, 32'hF07F_FFFF);
        #(PERIOD/4 + 1);
        check("R9 sys top", {30'h0, bm_target}, 32'h0);

        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule